// File: doc/BRIEF.md
# Consumer Channel-Status Block Source

This block holds the fixed 192-bit channel-status block of a two-channel consumer-format digital audio stream and serves it one bit at a time. A framer that assembles subframes reads the bit for the current frame number and channel, and places it in the status slot of that subframe. Each channel has its own 24-byte block. The fields are constant: the copy-permitted flag, a general category, the channel number and the 32 kHz sample-rate code. A CRC that protects the block sits in the last byte.

When reset is released, the block walks the 192 status bits of both channels in frame order. It feeds each bit to a serial CRC lane for that channel, one bit per clock. When the walk ends, a ready flag rises and the stored CRCs complete the blocks. Reads are combinational: the addressed bit follows the frame index and channel select in the same cycle. Frame number f maps to byte f/8, bit f mod 8, with bit 0 the least significant bit of the byte.

Top module: `chstat_gen`

## Requirements
- R1: In byte 0 (frames 0 to 7) only bit 2, the copy-permitted flag at frame 2, reads 1. This holds for both channels.
- R2: Byte 1 (frames 8 to 15), the category code, reads 0 for both channels.
- R3: Byte 2 holds the channel number in its upper nibble, value 1 for the left channel (chan_sel 0, frame 20 set) and value 2 for the right channel (chan_sel 1, frame 21 set). Its lower nibble reads 0.
- R4: Byte 3 holds the 32 kHz code, bits 0 and 1 set (frames 24 and 25). Its other bits read 0.
- R5: Bytes 4 to 22 (frames 32 to 183) read 0.
- R6: Byte 23 (frames 184 to 191) of each channel holds an 8-bit CRC of that channel's 24 bytes, with byte 23 taken as zero. The CRC register starts at 0xFF and bits are taken in frame order, least significant bit of each byte first. For each bit the register shifts right, and when the old register bit 0 XOR the data bit is 1, the shifted value is XORed with 0xB8.
- R7: ready is 0 in reset and stays 0 for the first 191 rising edges after reset is released. It reads 1 after the 192nd edge and stays 1 until the next reset.
- R8: While ready is 0, status_bit reads 0 for every frame index and channel.
- R9: A frame index from 192 to 255 reads 0 on status_bit.
- R10: status_bit is a combinational function of frame_idx and chan_sel once ready is 1, valid in the same cycle the index is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; restarts the CRC walk |
| frame_idx | input | 8 | Frame number whose status bit is requested |
| chan_sel | input | 1 | 0 selects the left channel, 1 the right |
| status_bit | output | 1 | Requested channel-status bit |
| ready | output | 1 | High once both CRCs are complete |

## Verification
The assertions assume that reset is held for at least one edge and that frame_idx and chan_sel may change freely in any cycle. They make no assumption about the index being in range, because out-of-range reads are part of the defined behaviour. The stimulus reads across the whole 191-cycle start-up window, including the edge where ready rises, with indexes that sweep every byte. It then covers each frame of both channels and several indexes above 191. All inputs change only just after a rising edge, so every read rests on a settled index for the rest of the cycle.

// File: rtl/chstat_pkg.sv
package chstat_pkg;
    parameter int NUM_CHAN   = 2;
    parameter int BYTE_W     = 8;
    parameter int NUM_BYTES  = 24;
    parameter int IDX_W      = 8;
    parameter logic [BYTE_W-1:0] CRC_POLY = 8'hB8;
    parameter logic [BYTE_W-1:0] CRC_SEED = 8'hFF;

    localparam int NUM_FRAMES = NUM_BYTES * BYTE_W;
    localparam int BIT_SEL_W  = $clog2(BYTE_W);
    localparam int BYTE_SEL_W = $clog2(NUM_BYTES);
    localparam int CRC_BYTE   = NUM_BYTES - 1;

    // fixed field positions
    localparam int COPY_OK_BIT   = 2;
    localparam int CHAN_NUM_LSB  = 4;
    localparam logic [BYTE_W-1:0] RATE_32K_CODE = 8'h03;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic [IDX_W-1:0] walk;
        logic             ready;
    } seq_state_t;
endpackage

// File: rtl/chstat_field_rom.sv
module chstat_field_rom
    import chstat_pkg::*;
(
    input  logic [BYTE_SEL_W-1:0] byte_sel,
    input  logic                  right_chan,
    output byte_t                 value
);
    always_comb begin
        value = '0;
        unique case (byte_sel)
            BYTE_SEL_W'(0): value[COPY_OK_BIT] = 1'b1;
            BYTE_SEL_W'(2): value = right_chan ? byte_t'(2 << CHAN_NUM_LSB)
                                               : byte_t'(1 << CHAN_NUM_LSB);
            BYTE_SEL_W'(3): value = RATE_32K_CODE;
            default:        value = '0;
        endcase
    end
endmodule

// File: rtl/chstat_crc_lane.sv
module chstat_crc_lane
    import chstat_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    input  logic  data_bit,
    output byte_t crc
);
    byte_t crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (step) begin
            crc_d = crc_q >> 1;
            if (crc_q[0] ^ data_bit) begin
                crc_d = crc_d ^ CRC_POLY;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc = crc_q;
endmodule

// File: rtl/chstat_gen.sv
module chstat_gen
    import chstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] frame_idx,
    input  logic             chan_sel,
    output logic             status_bit,
    output logic             ready
);
    seq_state_t st_d, st_q;
    byte_t      crc_w [NUM_CHAN];

    logic [BYTE_SEL_W-1:0] walk_byte;
    logic [BIT_SEL_W-1:0]  walk_bit;
    assign walk_byte = st_q.walk[BIT_SEL_W +: BYTE_SEL_W];
    assign walk_bit  = st_q.walk[BIT_SEL_W-1:0];

    // one feed path and one CRC lane per channel
    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_lane
        byte_t feed_byte;
        chstat_field_rom i_feed_rom (
            .byte_sel   (walk_byte),
            .right_chan (ch[0]),
            .value      (feed_byte)
        );
        chstat_crc_lane i_crc (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (!st_q.ready),
            .data_bit (feed_byte[walk_bit]),
            .crc      (crc_w[ch])
        );
    end

    // sequencer: one status bit per clock, both channels together
    always_comb begin
        st_d = st_q;
        if (!st_q.ready) begin
            if (st_q.walk == IDX_W'(NUM_FRAMES - 1)) begin
                st_d.ready = 1'b1;
                st_d.walk  = '0;
            end else begin
                st_d.walk = st_q.walk + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // combinational read path
    logic [BYTE_SEL_W-1:0] rd_byte_sel;
    logic [BIT_SEL_W-1:0]  rd_bit_sel;
    byte_t                 rd_field;
    byte_t                 rd_byte;
    logic                  rd_in_range;

    assign rd_byte_sel = frame_idx[BIT_SEL_W +: BYTE_SEL_W];
    assign rd_bit_sel  = frame_idx[BIT_SEL_W-1:0];
    assign rd_in_range = frame_idx < IDX_W'(NUM_FRAMES);

    chstat_field_rom i_read_rom (
        .byte_sel   (rd_byte_sel),
        .right_chan (chan_sel),
        .value      (rd_field)
    );

    always_comb begin
        rd_byte = rd_field;
        if (rd_byte_sel == BYTE_SEL_W'(CRC_BYTE)) begin
            rd_byte = crc_w[chan_sel];
        end
    end

    assign status_bit = st_q.ready && rd_in_range && rd_byte[rd_bit_sel];
    assign ready      = st_q.ready;
endmodule

// File: rtl/chstat_chk.sv
module chstat_chk
    import chstat_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] frame_idx,
    input logic             chan_sel,
    input logic             status_bit,
    input logic             ready
);
    logic [IDX_W:0] cyc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (cyc_q != '1) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    AST_READY_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        ready == (cyc_q >= (IDX_W+1)'(NUM_FRAMES))); // R7

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R7

    AST_ZERO_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !status_bit); // R8

    AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_idx >= IDX_W'(NUM_FRAMES)) |-> !status_bit); // R9

    AST_CATEGORY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_idx[IDX_W-1:3] == 5'd1) |-> !status_bit); // R2

    AST_CONTROL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && frame_idx[IDX_W-1:3] == 5'd0) |-> (status_bit == (frame_idx == 8'd2))); // R1

    AST_CHAN_NUMBER: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && frame_idx[IDX_W-1:3] == 5'd2)
        |-> (status_bit == (frame_idx == (chan_sel ? 8'd21 : 8'd20)))); // R3

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_idx >= 8'd32 && frame_idx < 8'd184) |-> !status_bit); // R5
endmodule

bind chstat_gen chstat_chk i_chk (.*);

// File: tb/test_chstat_gen.sv
module test_chstat_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NFR = 192;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] frame_idx = '0;
    logic       chan_sel = 1'b0;
    logic       status_bit;
    logic       ready;

    int checks = 0;
    int errors = 0;
    int edges = 0;
    bit done = 0;

    typedef struct {
        logic       exp_bit;
        logic       exp_ready;
        string      tag;
        logic [7:0] f;
        logic       ch;
    } item_t;
    item_t sb_q[$];

    logic [7:0] model [2][24];

    chstat_gen i_chstat_gen (
        .clk(clk), .rst_n(rst_n), .frame_idx(frame_idx),
        .chan_sel(chan_sel), .status_bit(status_bit), .ready(ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst_n) edges <= edges + 1;
    end

    function automatic void build_model();
        for (int c = 0; c < 2; c++) begin
            logic [7:0] r;
            for (int b = 0; b < 24; b++) model[c][b] = 8'h00;
            model[c][0] = 8'h04;                 // R1
            model[c][2] = (c == 0) ? 8'h10 : 8'h20; // R3
            model[c][3] = 8'h03;                 // R4
            r = 8'hFF;                           // R6
            for (int b = 0; b < 24; b++) begin
                for (int j = 0; j < 8; j++) begin
                    logic fb;
                    fb = r[0] ^ model[c][b][j];
                    r = r >> 1;
                    if (fb) r = r ^ 8'hB8;
                end
            end
            model[c][23] = r;
        end
    endfunction

    function automatic string tag_of(int f);
        if (f >= NFR) return "R9";
        if (f < 8) return "R1";
        if (f < 16) return "R2";
        if (f < 24) return "R3";
        if (f < 32) return "R4";
        if (f < 184) return "R5";
        return "R6";
    endfunction

    // driver: applies a read just after an edge and pushes its expectation
    task automatic drive(input int f, input bit ch);
        item_t it;
        @(posedge clk);
        #1;
        frame_idx = 8'(f);
        chan_sel = ch;
        it.exp_ready = (edges >= NFR);
        if (!it.exp_ready) begin
            it.exp_bit = 1'b0;
            it.tag = "R8";
        end else if (f >= NFR) begin
            it.exp_bit = 1'b0;
            it.tag = "R9";
        end else begin
            it.exp_bit = model[ch][f/8][f%8];
            it.tag = {tag_of(f), "/R10"};
        end
        it.f = 8'(f);
        it.ch = ch;
        sb_q.push_back(it);
    endtask

    // monitor: compares at the falling edge of the same cycle
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (status_bit !== it.exp_bit) begin
                    errors++;
                    $display("FAIL %s frame=%0d ch=%0d status_bit actual=%b expected=%b",
                             it.tag, it.f, it.ch, status_bit, it.exp_bit);
                end
                checks++;
                if (ready !== it.exp_ready) begin
                    errors++;
                    $display("FAIL R7 edges=%0d ready actual=%b expected=%b",
                             edges, ready, it.exp_ready);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        build_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (ready !== 1'b0) begin
            errors++;
            $display("FAIL R7 in reset ready actual=%b expected=0", ready);
        end
        rst_n = 1'b1;
        // start-up window, crossing the edge where ready rises (R7, R8)
        for (int k = 0; k < 200; k++) begin
            drive((k * 7 + 2) % 192, k[0]);
        end
        // full sweep of both channels
        for (int c = 0; c < 2; c++) begin
            for (int f = 0; f < NFR; f++) begin
                drive(f, c[0]);
            end
        end
        // indexes above the block (R9)
        drive(192, 1'b0);
        drive(200, 1'b1);
        drive(255, 1'b0);
        drive(223, 1'b1);
        // index changes every cycle between channels (R10)
        for (int k = 0; k < 16; k++) begin
            drive(184 + (k % 8), k[0]);
        end
        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule